// File: doc/BRIEF.md
# Three-Phase PWM Generator with Shared Clear Point

This block drives the six switches of a three-phase bridge from one timebase. A single up-counter runs from zero to a programmed period value and then clears. Each of the three phases has its own threshold. Its positive output is high from the clear until the counter reaches that threshold, and its complementary output is the inverse. Because every phase rises at the same counter clear, all three waveforms share one common transition point. Only the falling edge of each phase moves as its threshold changes.

Software writes four compare values: the period and three thresholds. Each write lands in a holding register. The values in use are replaced only at a counter clear, or at once while the generator is disabled, so a period never mixes old and new settings. A second counter on the paired channel keeps counting every clock and never takes part in any comparison.

The control state machine has two states. ST_IDLE holds the counter at zero with all outputs low. ST_RUN counts. There are three transitions:
- LAUNCH goes from ST_IDLE to ST_RUN when the enable is high.
- WRAP stays in ST_RUN when the count equals the period. It clears the counter and loads the held compare values.
- HALT goes from ST_RUN to ST_IDLE when the enable is low.

Top module: `rsync_pwm3`

## Requirements
- R1: While the enable is low (state ST_IDLE), `base_cnt` is 0 and all six PWM outputs are low, including right after reset.
- R2: While running, `base_cnt` steps 0, 1, … up to the active period value and then returns to 0, so one PWM period lasts period+1 clocks.
- R3: While running, `pwm_p[i]` is high exactly when `base_cnt` is below the active threshold of phase i. It rises at the counter clear and falls on compare match with that threshold.
- R4: While running, `pwm_n[i]` is the complement of `pwm_p[i]`, and the two are never high together.
- R5: Every phase whose threshold is nonzero goes high in the same cycle, the one where `base_cnt` is 0. No positive output rises at any other count.
- R6: A threshold larger than the period gives 100% duty, with `pwm_p` high for all period+1 clocks. A threshold of 0 gives 0% duty.
- R7: A compare write made while running leaves the current period unchanged and takes effect from the next counter clear. While idle, a written value is in use one clock after the write.
- R8: `aux_cnt` increases by one every clock from reset and wraps at its width. The enable and the compare writes have no effect on it.
- R9: `cfg_sel` encodes the target of a write as follows: 0 is the period, 1 is the phase-0 threshold, 2 is the phase-1 threshold and 3 is the phase-2 threshold.
- R10: When the enable drops during a period, the next clock returns the block to ST_IDLE, with the counter at 0 and the outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Mode enable; high runs the generator |
| cfg_we | input | 1 | Write strobe for a compare value |
| cfg_sel | input | 2 | Compare register select (see R9) |
| cfg_data | input | W | Compare value to write |
| pwm_p | output | 3 | Positive PWM output per phase |
| pwm_n | output | 3 | Complementary PWM output per phase |
| base_cnt | output | W | Shared timebase count |
| aux_cnt | output | W | Independent counter of the paired channel |

## Verification
The main function is tried with five parameter sets. Staggered thresholds separate the three comparators and the select decoding. A 0 threshold and a threshold above the period isolate the two duty-cycle limits. A threshold equal to the period, and one equal to period+1, pin down the off-by-one at the compare match. A period of 1 exercises the shortest legal cycle. A write made mid-period tells buffered loading apart from an immediate update, and dropping the enable mid-period checks the return to idle.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    localparam int NUM_PHASES = 3;
    localparam int NUM_CMP    = NUM_PHASES + 1;
    localparam int SEL_W      = $clog2(NUM_CMP);

    // Write target encoding: 0 period, 1..3 phase thresholds
    typedef enum logic [SEL_W-1:0] {
        SEL_PERIOD = 2'd0,
        SEL_PH0    = 2'd1,
        SEL_PH1    = 2'd2,
        SEL_PH2    = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tb_state_e;
endpackage

// File: rtl/rsp_regbank.sv
module rsp_regbank
    import rsp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [SEL_W-1:0]               sel,
    input  logic [W-1:0]                   data,
    input  logic                           load,
    output logic [W-1:0]                   per_act,
    output logic [NUM_PHASES-1:0][W-1:0]   thr_act
);
    logic [NUM_CMP-1:0][W-1:0] hold_q;
    logic [NUM_CMP-1:0][W-1:0] act_q;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q[g] <= '0;
            end else if (we && (sel == SEL_W'(g))) begin
                hold_q[g] <= data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q[g] <= '0;
            end else if (load) begin
                act_q[g] <= hold_q[g];
            end
        end
    end

    assign per_act = act_q[SEL_PERIOD];

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_thr
        assign thr_act[p] = act_q[p+1];
    end
endmodule

// File: rtl/rsp_timebase.sv
module rsp_timebase
    import rsp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         running,
    output logic         load
);
    tb_state_e    state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         wrap;

    assign wrap = (cnt_q == per);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: LAUNCH, WRAP, HALT
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (!wrap) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        running = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: load = 1'b1;
            ST_RUN: begin
                running = 1'b1;
                load    = wrap;
            end
        endcase
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rsp_phase.sv
module rsp_phase #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] thr,
    input  logic         running,
    output logic         p,
    output logic         n
);
    logic below;

    assign below = (cnt < thr);
    assign p     = running & below;
    assign n     = running & ~below;
endmodule

// File: rtl/rsp_aux_counter.sv
module rsp_aux_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rsync_pwm3.sv
module rsync_pwm3
    import rsp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [W-1:0]          cfg_data,
    output logic [NUM_PHASES-1:0] pwm_p,
    output logic [NUM_PHASES-1:0] pwm_n,
    output logic [W-1:0]          base_cnt,
    output logic [W-1:0]          aux_cnt
);
    logic                         running;
    logic                         load;
    logic [W-1:0]                 per_act;
    logic [NUM_PHASES-1:0][W-1:0] thr_act;

    rsp_regbank #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .data    (cfg_data),
        .load    (load),
        .per_act (per_act),
        .thr_act (thr_act)
    );

    rsp_timebase #(.W(W)) u_tbase (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .per     (per_act),
        .cnt     (base_cnt),
        .running (running),
        .load    (load)
    );

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
        rsp_phase #(.W(W)) u_ph (
            .cnt     (base_cnt),
            .thr     (thr_act[i]),
            .running (running),
            .p       (pwm_p[i]),
            .n       (pwm_n[i])
        );
    end

    rsp_aux_counter #(.W(W)) u_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (aux_cnt)
    );
endmodule

// File: rtl/rsync_pwm3_chk.sv
module rsync_pwm3_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   pwm_p,
    input logic [2:0]   pwm_n,
    input logic [W-1:0] base_cnt,
    input logic [W-1:0] aux_cnt,
    input logic         running,
    input logic [W-1:0] per_act
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_p == 3'b000 && pwm_n == 3'b000 && base_cnt == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (base_cnt != '0) |-> (base_cnt == $past(base_cnt) + 1'b1));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_p & pwm_n) == 3'b000);

    assert_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ((pwm_p ^ pwm_n) == 3'b111));

    assert_common_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_p & ~$past(pwm_p)) != 3'b000) |-> (base_cnt == '0));

    assert_period_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && base_cnt != '0) |-> $stable(per_act));

    assert_aux_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (aux_cnt == $past(aux_cnt) + 1'b1));
endmodule

bind rsync_pwm3 rsync_pwm3_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_p    (pwm_p),
    .pwm_n    (pwm_n),
    .base_cnt (base_cnt),
    .aux_cnt  (aux_cnt),
    .running  (running),
    .per_act  (per_act)
);

// File: tb/rsync_pwm3_test.sv
module rsync_pwm3_test;
    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 5;
    // period, threshold phase0, phase1, phase2
    localparam int VEC [NVEC][4] = '{
        '{9, 3, 5, 7},
        '{4, 0, 5, 2},
        '{7, 8, 1, 7},
        '{15, 15, 16, 0},
        '{1, 1, 2, 0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [W-1:0] cfg_data = '0;
    logic [2:0]   pwm_p, pwm_n;
    logic [W-1:0] base_cnt, aux_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsync_pwm3 #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .pwm_p(pwm_p),
        .pwm_n(pwm_n), .base_cnt(base_cnt), .aux_cnt(aux_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int sel, input int val);
        cfg_we   = 1'b1;
        cfg_sel  = sel[1:0];
        cfg_data = val[W-1:0];
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    initial begin
        int h [3];
        int a0;
        int hb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_p == 3'b000, "R1 reset pwm_p", int'(pwm_p), 0);
        check(pwm_n == 3'b000, "R1 reset pwm_n", int'(pwm_n), 0);
        check(base_cnt == '0, "R1 reset base_cnt", int'(base_cnt), 0);

        // table walk: R9 selects, R2/R3/R4/R5/R6 per vector
        for (int v = 0; v < NVEC; v++) begin
            int p;
            p = VEC[v][0];
            run_en = 1'b0;
            @(negedge clk);
            for (int s = 0; s < 4; s++) wr(s, VEC[v][s]);
            @(negedge clk);
            run_en = 1'b1;
            @(negedge clk);
            for (int i = 0; i < 3; i++) h[i] = 0;
            for (int k = 0; k <= p; k++) begin
                check(int'(base_cnt) == k, "R2 count", int'(base_cnt), k);
                for (int i = 0; i < 3; i++) begin
                    check(pwm_n[i] == ~pwm_p[i], "R4 complement", int'(pwm_n[i]), int'(~pwm_p[i]));
                    if (pwm_p[i]) h[i]++;
                    if (k == 0)
                        check(pwm_p[i] == (VEC[v][i+1] != 0), "R5 common rise",
                              int'(pwm_p[i]), int'(VEC[v][i+1] != 0));
                end
                @(negedge clk);
            end
            check(base_cnt == '0, "R2 clear after period", int'(base_cnt), 0);
            for (int i = 0; i < 3; i++) begin
                int t, e;
                t = VEC[v][i+1];
                e = (t > p) ? p + 1 : t;
                if (t == 0 || t > p) check(h[i] == e, "R6 duty limit (R9 select)", h[i], e);
                else                 check(h[i] == e, "R3 high time (R9 select)", h[i], e);
            end
        end

        // R10: drop enable mid-period
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(base_cnt == '0, "R10 counter idle", int'(base_cnt), 0);
        check(pwm_p == 3'b000, "R10 pwm_p idle", int'(pwm_p), 0);
        check(pwm_n == 3'b000, "R10 pwm_n idle", int'(pwm_n), 0);

        // R7: buffered update while running
        wr(0, 9); wr(1, 3); wr(2, 5); wr(3, 7);
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check(int'(base_cnt) == 3, "R7 setup count", int'(base_cnt), 3);
        wr(0, 5);
        wr(1, 2);
        for (int k = 5; k <= 9; k++) begin
            check(int'(base_cnt) == k, "R7 old period kept", int'(base_cnt), k);
            check(pwm_p[0] == 1'b0, "R7 old threshold kept", int'(pwm_p[0]), 0);
            @(negedge clk);
        end
        hb = 0;
        for (int k = 0; k <= 5; k++) begin
            check(int'(base_cnt) == k, "R7 new period count", int'(base_cnt), k);
            if (pwm_p[0]) hb++;
            @(negedge clk);
        end
        check(base_cnt == '0, "R7 new period clear", int'(base_cnt), 0);
        check(hb == 2, "R7 new threshold", hb, 2);

        // R8: aux counter independent of enable and writes
        a0 = int'(aux_cnt);
        run_en = 1'b0;
        wr(2, 1);
        @(negedge clk);
        run_en = 1'b1;
        repeat (4) @(negedge clk);
        check(int'(aux_cnt) == ((a0 + 6) & 16'hFFFF), "R8 aux count", int'(aux_cnt), (a0 + 6) & 16'hFFFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule